// File: doc/BRIEF.md
# MDIO Management Master

This block drives a two-wire station management bus using the short (Clause 22) frame format. Software composes one 32-bit command word: an operation code, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. Setting the go bit in that word launches the frame. The block derives the management clock from its reference clock, shifts out the preamble and the frame header, and handles the turnaround. It then either drives the 16 write data bits or captures the 16 bits returned by the PHY.

The command word reads back with a busy flag, a turnaround-failure flag and, after a read, the captured data in its low half. A separate configuration word sets the clock divider and can drop the preamble for PHYs that accept short frames. The bidirectional data line appears as separate output, output-enable and input pins, so the pad ring supplies the tristate buffer and the pull-up.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the command word reads 0, the configuration word reads 0x41 (divider 4, preamble on, Clause 22 bit set), MDC is low and the data line is not driven.
- R2: Command word layout: bits 27:26 opcode, 25:21 PHY address, 20:16 register address, 15:0 data. A command write with bit 29 clear only stores these fields and sends no frame. Any accepted command write clears the failure flag.
- R3: Writing the command word with bit 29 set while idle starts a frame. Bit 29 reads 1 for exactly 2*N*(div+1) reference cycles, where N is the number of frame bits, and then clears by itself.
- R4: MDC is low while idle. During a frame it has a period of 2*(div+1) reference cycles and stays high for div+1 cycles per bit. div is configuration bits 9:4.
- R5: A frame opens with 32 driven ones unless configuration bit 12 is set, in which case there is no preamble.
- R6: After the preamble, the block drives 0, 1, the two opcode bits, the PHY address and the register address, each MSB first. Opcode 2 (binary 10) selects a read; opcode 1 (binary 01) selects a write.
- R7: In a write, the turnaround is driven as 1 then 0, followed by the 16 data bits MSB first.
- R8: In a read, the line is released from the first turnaround bit to the end of the frame. The 16 bits sampled on MDC rising edges, MSB first, appear in command bits 15:0 once busy clears.
- R9: Bit 28 is set at the end of a read in which the line was high at the rising edge of the second turnaround bit. Otherwise it reads 0.
- R10: The data line and its enable change only on MDC falling edges, so they are stable while MDC is high.
- R11: A command write made while busy is ignored. The fields and the frame in progress are unchanged, and no new frame follows.
- R12: The data line enable is low whenever the block is idle.
- R13: The configuration word keeps only bit 12 and bits 9:4. Bit 0 always reads 1 and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command word, 1 the configuration word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A sweep of frames walks the PHY and register addresses across their ranges. It alternates reads and writes, cycles the divider through 0, 1 and 2, and toggles preamble suppression. This separates field placement errors from clock timing errors and from preamble counting errors. Reads use distinct data patterns, with a PHY model that either pulls the second turnaround bit low or leaves it floating, so capture order and the failure flag are told apart. A write issued mid-frame and a command stored without the go bit show that busy gating and launch are distinct.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = 32;
    localparam int HDR_LEN    = 14;
    localparam int TA2_IDX    = 15;
    localparam int DATA_IDX   = 16;
    localparam int DATA_BITS  = 16;
    localparam int ADDR_BITS  = 5;

    localparam int CMD_GO_BIT   = 29;
    localparam int CMD_FAIL_BIT = 28;
    localparam int CFG_SKIP_BIT = 12;
    localparam int CFG_DIV_LSB  = 4;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_FRAME = 2'd2
    } phase_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.cnt >= div);
        if (!run) begin
            d = '0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc       = q.mdc;
    assign rise_tick = run && wrap && !q.mdc;
    assign fall_tick = run && wrap && q.mdc;

    // R4: clock rests low when the generator is stopped
    assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !q.mdc);
    // R4: level holds until the half-period count is used up
    assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.cnt < div) |=> (q.mdc == $past(q.mdc)));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 skip_pre,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 ta_fail,
    output logic                 mdio_o,
    output logic                 mdio_oe
);
    localparam int MAXLEN = (PRE_LEN > FRAME_LEN) ? PRE_LEN : FRAME_LEN;
    localparam int CNT_W  = $clog2(MAXLEN);
    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_END    = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] TA2_POS    = CNT_W'(TA2_IDX);
    localparam logic [CNT_W-1:0] DATA_POS   = CNT_W'(DATA_IDX);

    typedef struct packed {
        phase_e                 phase;
        logic [CNT_W-1:0]       bitcnt;
        logic [FRAME_LEN-1:0]   sh;
        logic [DATA_BITS-1:0]   rx;
        logic                   ta_bad;
        logic                   rd;
    } eng_t;

    eng_t q, d;
    logic is_rd_cmd;

    always_comb begin
        d         = q;
        done      = 1'b0;
        is_rd_cmd = (op == OP_READ);
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.rd     = is_rd_cmd;
                    d.sh     = {2'b01, op, phy_addr, reg_addr,
                                (is_rd_cmd ? 2'b11 : 2'b10),
                                (is_rd_cmd ? {DATA_BITS{1'b1}} : wdata)};
                    d.ta_bad = 1'b0;
                    d.rx     = '0;
                    d.bitcnt = '0;
                    d.phase  = skip_pre ? PH_FRAME : PH_PRE;
                end
            end
            PH_PRE: begin
                if (fall_tick) begin
                    if (q.bitcnt == PRE_LAST) begin
                        d.phase  = PH_FRAME;
                        d.bitcnt = '0;
                    end else begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                end
            end
            PH_FRAME: begin
                if (rise_tick && q.rd) begin
                    if (q.bitcnt == TA2_POS)
                        d.ta_bad = mdio_i;
                    else if (q.bitcnt >= DATA_POS)
                        d.rx = {q.rx[DATA_BITS-2:0], mdio_i};
                end
                if (fall_tick) begin
                    d.sh = {q.sh[FRAME_LEN-2:0], 1'b0};
                    if (q.bitcnt == FRAME_LAST) begin
                        d.phase  = PH_IDLE;
                        d.bitcnt = '0;
                        done     = 1'b1;
                    end else begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{phase: PH_IDLE, default: '0};
        else        q <= d;
    end

    assign busy    = (q.phase != PH_IDLE);
    assign rd_data = q.rx;
    assign ta_fail = q.ta_bad;
    assign mdio_o  = (q.phase == PH_FRAME) ? q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = (q.phase == PH_PRE) ||
                     ((q.phase == PH_FRAME) && (!q.rd || q.bitcnt < HDR_END));

    // R10: line value and enable move only with a falling MDC tick
    assert_line_moves_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_tick) |=> ($stable(mdio_o) && $stable(mdio_oe)));
    // R8: a read never drives from the turnaround onward
    assert_read_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_FRAME && q.rd && q.bitcnt >= HDR_END) |-> !mdio_oe);
    // R3: completion only comes out of an active frame
    assert_done_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && fall_tick));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int         DIV_W     = 6,
    parameter logic [5:0] DIV_RESET = 6'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [1:0]           op;
        logic [ADDR_BITS-1:0] phy;
        logic [ADDR_BITS-1:0] regad;
        logic [DATA_BITS-1:0] data;
        logic                 fail;
        logic [DIV_W-1:0]     div;
        logic                 skip;
    } regs_t;

    regs_t q, d;

    logic                 cmd_wr, cfg_wr, start;
    logic                 busy, done, ta_fail, rise_tick, fall_tick;
    logic [DATA_BITS-1:0] rd_data;
    logic [1:0]           w_op;
    logic [ADDR_BITS-1:0] w_phy, w_reg;
    logic [DATA_BITS-1:0] w_data;
    logic [31:0]          cmd_word, cfg_word;
    logic                 unused_wdata_bits;

    assign cmd_wr = reg_wr_en && !reg_sel;
    assign cfg_wr = reg_wr_en && reg_sel;
    assign w_op   = reg_wdata[27:26];
    assign w_phy  = reg_wdata[25:21];
    assign w_reg  = reg_wdata[20:16];
    assign w_data = reg_wdata[15:0];
    assign unused_wdata_bits = ^reg_wdata;

    always_comb begin
        d     = q;
        start = 1'b0;
        if (cmd_wr && !busy) begin
            d.op    = w_op;
            d.phy   = w_phy;
            d.regad = w_reg;
            d.data  = w_data;
            d.fail  = 1'b0;
            start   = reg_wdata[CMD_GO_BIT];
        end
        if (done && q.op == OP_READ) begin
            d.data = rd_data;
            d.fail = ta_fail;
        end
        if (cfg_wr) begin
            d.div  = reg_wdata[CFG_DIV_LSB +: DIV_W];
            d.skip = reg_wdata[CFG_SKIP_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{div: DIV_W'(DIV_RESET), default: '0};
        else        q <= d;
    end

    always_comb begin
        cmd_word = {2'b00, busy, q.fail, q.op, q.phy, q.regad, q.data};
        cfg_word = '0;
        cfg_word[CFG_SKIP_BIT]              = q.skip;
        cfg_word[CFG_DIV_LSB +: DIV_W]      = q.div;
        cfg_word[0]                         = 1'b1;
        reg_rdata = reg_sel ? cfg_word : cmd_word;
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (q.div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (w_op),
        .phy_addr  (w_phy),
        .reg_addr  (w_reg),
        .wdata     (w_data),
        .skip_pre  (q.skip),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .ta_fail   (ta_fail),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    // R11: a command write during a frame leaves the stored fields alone
    assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(q.op) && $stable(q.phy) && $stable(q.regad)));
    // R3: a frame begins only after a command write carrying the go bit
    assert_start_from_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr && reg_wdata[CMD_GO_BIT]));
    // R12: idle line is left to the pull-up
    assert_idle_undriven_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // PHY model state
    int          rc = 0;
    int          pre_exp = 32;
    bit          phy_is_read = 0;
    bit          phy_ta_drive = 1;
    logic [15:0] phy_data = '0;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    int          hi_cnt = 0;
    int          contention = 0;
    int          r10_viol = 0;
    logic        prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_mgmt_master uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual %0d expected below %0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(posedge mdc) begin
        if (rc < 64) begin
            cap_o[rc]  = mdio_o;
            cap_oe[rc] = mdio_oe;
        end
        rc++;
    end

    always @(negedge mdc) begin
        int k;
        k = rc - pre_exp;
        if (phy_is_read && k == 15 && phy_ta_drive) begin
            phy_en = 1'b1; phy_val = 1'b0;
        end else if (phy_is_read && k >= 16 && k <= 31) begin
            phy_en = 1'b1; phy_val = phy_data[31-k];
        end else begin
            phy_en = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (mdio_oe && phy_en) contention++;
        if (mdc) hi_cnt++;
        if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) r10_viol++;
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic wr_reg(input bit sel, input logic [31:0] w);
        @(negedge clk);
        reg_sel = sel; reg_wdata = w; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rd_reg(input bit sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        rd_reg(1'b0, v);
        while (v[29]) begin
            n++;
            @(negedge clk);
            rd_reg(1'b0, v);
        end
    endtask

    task automatic do_txn(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input int dv, input bit sp,
                          input bit tad, input logic [15:0] rdv);
        int nb, bc;
        logic [13:0] hdr;
        logic [17:0] tail;
        logic [31:0] v, exp_word;
        bit ok;
        wr_reg(1'b1, (32'(sp) << 12) | (32'(dv) << 4));
        phy_is_read = (op == 2'b10);
        phy_ta_drive = tad;
        phy_data = rdv;
        pre_exp = sp ? 0 : 32;
        rc = 0; hi_cnt = 0; cap_o = '0; cap_oe = '0;
        wr_reg(1'b0, {2'b00, 1'b1, 1'b0, op, pa, ra, wd});
        wait_idle(bc);
        nb = pre_exp + 32;
        check(bc == 2 * nb * (dv + 1), "R3 busy length", bc, 2 * nb * (dv + 1));
        check(hi_cnt == nb * (dv + 1), "R4 mdc high time", hi_cnt, nb * (dv + 1));
        check(rc == nb, "R5 rising edge count", rc, nb);
        ok = 1;
        for (int i = 0; i < pre_exp; i++) if (cap_o[i] !== 1'b1 || cap_oe[i] !== 1'b1) ok = 0;
        check(ok, "R5 preamble ones", cap_o[31:0], 32'hFFFF_FFFF);
        hdr = {2'b01, op, pa, ra};
        ok = 1;
        for (int i = 0; i < 14; i++)
            if (cap_o[pre_exp + i] !== hdr[13-i] || cap_oe[pre_exp + i] !== 1'b1) ok = 0;
        check(ok, "R6 header bits", 32'(op), 32'(hdr));
        ok = 1;
        if (op == 2'b10) begin
            for (int i = 14; i < 32; i++) if (cap_oe[pre_exp + i] !== 1'b0) ok = 0;
            check(ok, "R8 line released", 32'(pa), 32'(ra));
        end else begin
            tail = {2'b10, wd};
            for (int i = 14; i < 32; i++)
                if (cap_o[pre_exp + i] !== tail[31-i] || cap_oe[pre_exp + i] !== 1'b1) ok = 0;
            check(ok, "R7 turnaround and data", 32'(wd), 32'(tail));
        end
        rd_reg(1'b0, v);
        exp_word = {2'b00, 1'b0, (op == 2'b10) && !tad, op, pa, ra,
                    (op == 2'b10) ? rdv : wd};
        check(v == exp_word, (op == 2'b10) ? "R8 R9 read result" : "R2 stored fields",
              v, exp_word);
        check(!mdc && !mdio_oe, "R12 idle pins", {30'b0, mdc, mdio_oe}, 32'h0);
    endtask

    initial begin
        logic [31:0] v, w;
        int bc, rc_save;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(1'b0, v);
        check(v == 32'h0, "R1 command reset", v, 32'h0);
        rd_reg(1'b1, v);
        check(v == 32'h41, "R1 config reset", v, 32'h41);
        check(!mdc && !mdio_oe, "R1 idle pins", {30'b0, mdc, mdio_oe}, 32'h0);

        wr_reg(1'b1, 32'hFFFF_FFFF);
        rd_reg(1'b1, v);
        check(v == 32'h13F1, "R13 config mask", v, 32'h13F1);

        for (int i = 0; i < 24; i++) begin
            do_txn((i % 2 == 1) ? 2'b10 : 2'b01, 5'((i * 7) % 32), 5'((i * 13 + 5) % 32),
                   16'(i * 16'h1357) ^ 16'hA5C3, i % 3, ((i / 2) % 2) == 1, 1'b1,
                   16'(i * 16'h2F1B) ^ 16'h5A3C);
        end

        // R9: floating second turnaround bit raises the failure flag
        do_txn(2'b10, 5'd31, 5'd0, 16'h0, 1, 1'b0, 1'b0, 16'hC3A5);
        // R2: a command without the go bit only stores fields and clears the flag
        rc = 0;
        w = {2'b00, 1'b0, 1'b0, 2'b10, 5'd17, 5'd3, 16'h5A5A};
        wr_reg(1'b0, w);
        repeat (40) @(negedge clk);
        rd_reg(1'b0, v);
        check(v == w, "R2 store without go clears R9 flag", v, w);
        check(rc == 0 && !mdc, "R2 no frame sent", rc, 0);

        // R11: write during a frame is ignored
        wr_reg(1'b1, (32'd1 << 12) | (32'd1 << 4));
        phy_is_read = 1; phy_ta_drive = 1; phy_data = 16'hBEEF; pre_exp = 0; rc = 0;
        wr_reg(1'b0, {2'b00, 1'b1, 1'b0, 2'b10, 5'd5, 5'd9, 16'h0});
        repeat (10) @(negedge clk);
        wr_reg(1'b0, {2'b00, 1'b1, 1'b0, 2'b01, 5'd30, 5'd2, 16'h1234});
        wait_idle(bc);
        rd_reg(1'b0, v);
        w = {2'b00, 1'b0, 1'b0, 2'b10, 5'd5, 5'd9, 16'hBEEF};
        check(v == w, "R11 fields kept", v, w);
        rc_save = rc;
        repeat (30) @(negedge clk);
        rd_reg(1'b0, v);
        check(!v[29] && rc == rc_save && rc_save == 32, "R11 no second frame", rc, 32);

        check(r10_viol == 0, "R10 line stable while mdc high", r10_viol, 0);
        check(contention == 0, "R8 no drive contention", contention, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule